// File: doc/BRIEF.md
# FM deviation and rate controller

This block forms the frequency word that drives a phase accumulator. It starts from a held carrier word and adds or subtracts a frequency-modulation term. The modulation term is a 16-bit unsigned magnitude with a separate subtract flag. A 2-bit scale code shifts the magnitude left by 0, 4, 8 or 12 bits before it is combined with the carrier. The sum wraps modulo 2^32 and is never saturated.

The modulation word can be taken in two ways. In manual mode it is taken on a falling edge of a load strobe. In automatic mode it is taken every 4, 8 or 16 clocks. Each automatic take is announced by a one-clock active-low sync pulse, so that an upstream source can present the next sample in step with it. Automatic taking runs only while the load strobe is held low.

A simultaneous-load flag lets a modulation take also capture a new carrier word. A separate carrier load strobe captures the carrier word on its own. When the flag is low, falling edges of the two strobes should be at least four clocks apart.

Top module: `fm_dev_ctrl`

## Requirements
- R1: While reset is asserted and after its release, before any load, `freq_word` is 0 and `sync_n` is 1.
- R2: With the captured subtract flag at 0, `freq_word` equals the carrier register plus the scaled modulation magnitude, modulo 2^32.
- R3: With the captured subtract flag at 1, `freq_word` equals the carrier register minus the scaled magnitude, modulo 2^32. A negative result wraps around.
- R4: `scale_sel` values 0, 1, 2 and 3 shift the magnitude left by 0, 4, 8 and 12 bits.
- R5: With `rate_sel` = 0, a falling edge of `fm_load` is first seen at clock edge E0. `fm_word` and `fm_sub` are captured at E1, and `freq_word` shows the new value after E2. It still holds the old value between E1 and E2.
- R6: With `rate_sel` = 1, 2 and 3 and `fm_load` held low, `sync_n` goes low every 4, 8 and 16 clocks respectively. Each low lasts exactly one clock.
- R7: In automatic mode, `fm_word` and `fm_sub` are captured on the edge that ends the sync low. `freq_word` reflects the capture one edge later.
- R8: In automatic mode with `fm_load` high, no sync pulse occurs and `freq_word` does not change.
- R9: With `rate_sel` = 0, no sync pulse occurs. Holding `fm_load` low after a manual load takes no further samples.
- R10: A modulation capture also captures `carrier_word` when `sim_load` is 1 at the capture edge. When `sim_load` is 0, the carrier register is left unchanged.
- R11: A falling edge of `car_load` seen at edge E0 captures `carrier_word` at E1, and `freq_word` reflects it after E2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fm_word | input | 16 | Unsigned modulation magnitude |
| fm_sub | input | 1 | 1 subtracts the modulation term, 0 adds it |
| scale_sel | input | 2 | Magnitude shift: 0, 4, 8 or 12 bits |
| rate_sel | input | 2 | 0 selects manual mode; 1, 2 and 3 select automatic mode every 4, 8 and 16 clocks |
| fm_load | input | 1 | Manual load on its falling edge; must be held low to allow automatic takes |
| sim_load | input | 1 | Modulation captures also take the carrier word |
| car_load | input | 1 | Carrier load on its falling edge |
| carrier_word | input | 32 | Carrier frequency word |
| freq_word | output | 32 | Registered frequency word |
| sync_n | output | 1 | Active-low one-clock automatic-take pulse |

## Verification
The bench uses the default build: a 16-bit magnitude, a 32-bit word, a 2-bit scale code with a 4-bit step and a 2-bit rate code. With these values, every scale code and both signs are swept against carriers near 0, near 2^32 and mid-range, which brings both wrap directions within reach. A counter of only 4 bits lets every rate code show several complete sync periods in a few dozen clocks. The two-edge load latency, the inhibit by a high `fm_load` and the carrier-take choice are timed edge by edge against the values the bench computes itself.

// File: rtl/fm_dev_pkg.sv
package fm_dev_pkg;
  typedef enum logic [1:0] {
    RATE_MANUAL = 2'd0,
    RATE_DIV4   = 2'd1,
    RATE_DIV8   = 2'd2,
    RATE_DIV16  = 2'd3
  } fm_rate_e;

  localparam int unsigned FM_W_DEF   = 16;
  localparam int unsigned FREQ_W_DEF = 32;
endpackage

// File: rtl/fm_rate_gen.sv
module fm_rate_gen #(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              fm_load,
  output logic              sync_n,
  output logic              cap
);
  localparam int unsigned CNT_W = 2**RATE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, mask;
  logic             ld_q, pend_q, pend_d, sync_q, sync_d;
  logic             auto_tick, man_fall;

  always_comb begin
    cnt_d     = cnt_q + 1'b1;
    mask      = CNT_W'((1 << (int'(rate_sel) + 1)) - 1);
    auto_tick = (rate_sel != '0) && ((cnt_q & mask) == mask) && !fm_load;
    man_fall  = (rate_sel == '0) && ld_q && !fm_load;
    sync_d    = !auto_tick;
    pend_d    = man_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ld_q   <= 1'b0;
      pend_q <= 1'b0;
      sync_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      ld_q   <= fm_load;
      pend_q <= pend_d;
      sync_q <= sync_d;
    end
  end

  assign sync_n = sync_q;
  assign cap    = pend_q | ~sync_q;

  // R6: a sync low never lasts more than one clock
  p_sync_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> sync_n);
  // R8 and R9: a sync low needs automatic mode with the strobe held low
  p_sync_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> ($past(rate_sel) != '0) && !$past(fm_load));
  // R5: a manual take follows a high-then-low strobe
  p_manual_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !$past(fm_load) && $past(fm_load, 2));
endmodule

// File: rtl/fm_load_regs.sv
module fm_load_regs #(
  parameter int unsigned FM_W   = 16,
  parameter int unsigned FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              sim_load,
  input  logic [FM_W-1:0]   fm_word,
  input  logic              fm_sub,
  input  logic              car_load,
  input  logic [FREQ_W-1:0] carrier_word,
  output logic [FM_W-1:0]   fm_mag,
  output logic              fm_neg,
  output logic [FREQ_W-1:0] car
);
  logic [FM_W-1:0]   mag_q, mag_d;
  logic              neg_q, neg_d;
  logic [FREQ_W-1:0] car_q, car_d;
  logic              cl_q, cpend_q, cpend_d, car_en;

  always_comb begin
    cpend_d = cl_q && !car_load;
    car_en  = cpend_q || (cap && sim_load);
    mag_d   = cap    ? fm_word      : mag_q;
    neg_d   = cap    ? fm_sub       : neg_q;
    car_d   = car_en ? carrier_word : car_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q   <= '0;
      neg_q   <= 1'b0;
      car_q   <= '0;
      cl_q    <= 1'b0;
      cpend_q <= 1'b0;
    end else begin
      mag_q   <= mag_d;
      neg_q   <= neg_d;
      car_q   <= car_d;
      cl_q    <= car_load;
      cpend_q <= cpend_d;
    end
  end

  assign fm_mag = mag_q;
  assign fm_neg = neg_q;
  assign car    = car_q;

  // R10: without a carrier strobe, a take with the flag low keeps the carrier
  p_car_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sim_load && !cpend_q) |=> (car == $past(car)));
endmodule

// File: rtl/fm_combine.sv
module fm_combine #(
  parameter int unsigned FM_W       = 16,
  parameter int unsigned FREQ_W     = 32,
  parameter int unsigned SCALE_W    = 2,
  parameter int unsigned SHIFT_STEP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FM_W-1:0]    fm_mag,
  input  logic               fm_neg,
  input  logic [SCALE_W-1:0] scale_sel,
  input  logic [FREQ_W-1:0]  car,
  output logic [FREQ_W-1:0]  freq_word
);
  localparam int unsigned N_SCALE = 2**SCALE_W;

  logic [FREQ_W-1:0] cand [N_SCALE];
  logic [FREQ_W-1:0] dev, freq_d, freq_q;

  for (genvar g = 0; g < N_SCALE; g++) begin : g_scale
    assign cand[g] = FREQ_W'(fm_mag) << (g * SHIFT_STEP);
  end

  always_comb begin
    dev    = cand[scale_sel];
    freq_d = fm_neg ? (car - dev) : (car + dev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freq_q <= '0;
    else        freq_q <= freq_d;
  end

  assign freq_word = freq_q;

  // R2: a zero magnitude passes the carrier through unchanged
  p_zero_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_mag == '0) |=> (freq_word == $past(car)));
endmodule

// File: rtl/fm_dev_ctrl.sv
module fm_dev_ctrl #(
  parameter int unsigned FM_W       = fm_dev_pkg::FM_W_DEF,
  parameter int unsigned FREQ_W     = fm_dev_pkg::FREQ_W_DEF,
  parameter int unsigned SCALE_W    = 2,
  parameter int unsigned SHIFT_STEP = 4,
  parameter int unsigned RATE_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FM_W-1:0]    fm_word,
  input  logic               fm_sub,
  input  logic [SCALE_W-1:0] scale_sel,
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic               fm_load,
  input  logic               sim_load,
  input  logic               car_load,
  input  logic [FREQ_W-1:0]  carrier_word,
  output logic [FREQ_W-1:0]  freq_word,
  output logic               sync_n
);
  logic              cap_w, fm_neg_w;
  logic [FM_W-1:0]   fm_mag_w;
  logic [FREQ_W-1:0] car_w;

  fm_rate_gen #(.RATE_W(RATE_W)) rate_i (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fm_load(fm_load),
    .sync_n(sync_n), .cap(cap_w)
  );

  fm_load_regs #(.FM_W(FM_W), .FREQ_W(FREQ_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cap(cap_w), .sim_load(sim_load),
    .fm_word(fm_word), .fm_sub(fm_sub), .car_load(car_load),
    .carrier_word(carrier_word), .fm_mag(fm_mag_w), .fm_neg(fm_neg_w),
    .car(car_w)
  );

  fm_combine #(.FM_W(FM_W), .FREQ_W(FREQ_W), .SCALE_W(SCALE_W),
               .SHIFT_STEP(SHIFT_STEP)) comb_i (
    .clk(clk), .rst_n(rst_n), .fm_mag(fm_mag_w), .fm_neg(fm_neg_w),
    .scale_sel(scale_sel), .car(car_w), .freq_word(freq_word)
  );

  // R7: the bus is taken on the edge that ends a sync low
  p_fm_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (fm_mag_w == $past(fm_word)) && (fm_neg_w == $past(fm_sub)));
endmodule

// File: tb/fm_dev_ctrl_tb.sv
`timescale 1ns/1ps
module fm_dev_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] fm_word;
  logic        fm_sub;
  logic [1:0]  scale_sel, rate_sel;
  logic        fm_load, sim_load, car_load;
  logic [31:0] carrier_word;
  logic [31:0] freq_word;
  logic        sync_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fm_dev_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fm_word(fm_word), .fm_sub(fm_sub),
    .scale_sel(scale_sel), .rate_sel(rate_sel), .fm_load(fm_load),
    .sim_load(sim_load), .car_load(car_load), .carrier_word(carrier_word),
    .freq_word(freq_word), .sync_n(sync_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] c, input logic [15:0] w,
                                        input logic s, input logic [1:0] sc);
    logic [31:0] d;
    d = {16'd0, w} << (4 * sc);
    return s ? c - d : c + d;
  endfunction

  // manual take; checks the held value between E1 and E2 and the result after E2
  task automatic man_load(input logic [15:0] w, input logic s, input logic [31:0] c,
                          input logic sim, input logic [31:0] old_v, input logic [31:0] exp);
    @(negedge clk);
    fm_word = w; fm_sub = s; carrier_word = c; sim_load = sim; fm_load = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 held before E2", freq_word, old_v);
    @(negedge clk);
    check("R2/R3/R4/R5 result", freq_word, exp);
    fm_load = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] cur, car_reg, e, cval;
    logic [15:0] wval;
    rst_n = 1'b0; fm_word = '0; fm_sub = 1'b0; scale_sel = '0; rate_sel = '0;
    fm_load = 1'b1; sim_load = 1'b0; car_load = 1'b1; carrier_word = '0;
    repeat (4) @(negedge clk);
    check("R1 reset freq", freq_word, 32'd0);
    check("R1 reset sync", {31'd0, sync_n}, 32'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle freq", freq_word, 32'd0);
    check("R1 idle sync", {31'd0, sync_n}, 32'd1);

    // sweep: every scale, both signs, several words and carriers (R2 R3 R4)
    cur = 32'd0;
    for (int sc = 0; sc < 4; sc++) begin
      @(negedge clk); scale_sel = 2'(sc);
      @(negedge clk);
      cur = model(car_reg, wval, fm_sub, 2'(sc));
      if (sc == 0) cur = freq_word;
      for (int s = 0; s < 2; s++) begin
        for (int wi = 0; wi < 3; wi++) begin
          for (int ci = 0; ci < 3; ci++) begin
            wval = (wi == 0) ? 16'h0001 : (wi == 1) ? 16'hFFFF : 16'h8A35;
            cval = (ci == 0) ? 32'h0000_0003 : (ci == 1) ? 32'hFFFF_FFF0 : 32'h1234_5678;
            e = model(cval, wval, s[0], 2'(sc));
            cur = freq_word;
            man_load(wval, s[0], cval, 1'b1, cur, e);
            car_reg = cval;
          end
        end
      end
    end

    // R10: take with sim_load low keeps the carrier register
    @(negedge clk); scale_sel = 2'd1;
    @(negedge clk);
    cur = freq_word;
    man_load(16'h0100, 1'b0, 32'hAAAA_0000, 1'b0, cur, model(car_reg, 16'h0100, 1'b0, 2'd1));

    // R11: carrier strobe alone
    @(negedge clk);
    cur = freq_word;
    carrier_word = 32'h0040_0000; car_load = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R11 held before E2", freq_word, cur);
    @(negedge clk);
    check("R11 carrier taken", freq_word, model(32'h0040_0000, 16'h0100, 1'b0, 2'd1));
    car_load = 1'b1; car_reg = 32'h0040_0000;

    // R9: manual mode with strobe held low after a take
    cur = freq_word;
    man_load(16'h0002, 1'b1, 32'h0, 1'b0, cur, model(car_reg, 16'h0002, 1'b1, 2'd1));
    @(negedge clk); fm_load = 1'b0; fm_word = 16'h0002;
    @(negedge clk); @(negedge clk); @(negedge clk);
    cur = freq_word;
    fm_word = 16'h7777;
    begin
      int lows = 0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (!sync_n) lows++;
      end
      check("R9 no sync in manual", 32'(lows), 32'd0);
      check("R9 no further take", freq_word, cur);
    end
    fm_load = 1'b1;

    // R8: automatic mode inhibited by high strobe
    @(negedge clk); rate_sel = 2'd1; fm_word = 16'h0F0F;
    cur = freq_word;
    begin
      int lows = 0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (!sync_n) lows++;
      end
      check("R8 no sync when inhibited", 32'(lows), 32'd0);
      check("R8 freq unchanged", freq_word, cur);
    end

    // R6: sync period and width per rate code
    for (int k = 1; k < 4; k++) begin
      int last;
      logic prev;
      @(negedge clk); rate_sel = 2'(k); fm_load = 1'b0; sim_load = 1'b0;
      last = -1; prev = 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (!sync_n) begin
          check("R6 width one clock", {31'd0, prev}, 32'd1);
          if (last >= 0) check("R6 period", 32'(i - last), 32'(1 << (k + 1)));
          last = i;
        end
        prev = sync_n;
      end
      check("R6 pulses seen", {31'd0, last >= 0}, 32'd1);
    end

    // R7: automatic capture timing
    @(negedge clk); rate_sel = 2'd2; fm_word = 16'h0123; fm_sub = 1'b0; scale_sel = 2'd2;
    begin
      int guard = 0;
      while (sync_n && guard < 40) begin @(negedge clk); guard++; end
      while (!sync_n && guard < 40) begin @(negedge clk); guard++; end
      while (sync_n && guard < 40) begin @(negedge clk); guard++; end
    end
    @(negedge clk); @(negedge clk);
    check("R7 auto take", freq_word, model(car_reg, 16'h0123, 1'b0, 2'd2));
    fm_load = 1'b1; rate_sel = 2'd0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule